// File: doc/BRIEF.md
# E1 Receive Channel Timing Generator

This block derives per-timeslot timing strobes for a 2.048 Mbit/s E1 receive stream. It runs on the receive bit clock. A one-clock alignment pulse fixes the frame position. After that pulse a free-running bit-position counter walks through the 256 bit periods of a frame. A frame holds 32 timeslots of eight bits, sent most significant bit first.

The block has four outputs:
- A channel strobe that marks the final bit of every timeslot, a 256 kHz rate.
- A per-timeslot block signal taken from a 32-bit mask, used to gate clocks for fractional E1 services.
- A regenerated sync pulse that marks either every frame or the first frame of each 16-frame multiframe.
- A retimed copy of the serial data.

All four outputs come from registers and line up with each other. The bit that `ser_out` shows comes with the strobe, block and sync values for that same bit position. The block stays quiet from reset until the first alignment pulse arrives.

Top module: `e1_rx_chan_timing`

## Requirements
- R1: From synchronous reset until the first clock edge that samples `align_in` high, `ser_out`, `chan_strobe`, `chan_block` and `sync_out` are all 0, whatever `ser_in` and the mask inputs do.
- R2: The `ser_in` bit sampled at the edge after the one that samples `align_in` high is bit position 0 of the frame: timeslot 0, its MSB. Position p then belongs to timeslot p/8 with bit index p mod 8, and a frame has positions 0 to 255.
- R3: Once aligned, `ser_out` after each rising edge equals the `ser_in` value sampled at that edge.
- R4: `chan_strobe` is 1 for exactly one clock in every eight, namely the clock in which `ser_out` carries bit index 7 (the LSB) of a timeslot.
- R5: With `mf_mode` = 0, `sync_out` is 1 for exactly one clock per frame, namely when `ser_out` carries frame position 0, once every 256 clocks.
- R6: With `mf_mode` = 1, `sync_out` is 1 only at position 0 of frame 0 of a 16-frame count. The alignment pulse resets the count to frame 0, so pulses come 4096 clocks apart.
- R7: Bit i of the active mask (bit 0 being timeslot 0, 1 meaning high) drives `chan_block` during all eight clocks in which `ser_out` carries timeslot i.
- R8: A value written with `mask_wr` becomes active at the next timeslot boundary. A write made in any clock with bit index 0 to 7 takes effect from bit 0 of the following timeslot and never changes `chan_block` within a timeslot. A write made in the clock with bit index 7 takes effect in the very next timeslot.
- R9: An alignment pulse while already aligned restarts the count at position 0 of frame 0 from the next bit, whatever the current position.
- R10: Asserting `rst` at any time returns all outputs to 0 after the next edge, and they stay 0 until a new alignment pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, 2.048 MHz |
| rst | input | 1 | Synchronous reset, active high |
| align_in | input | 1 | One-clock frame alignment pulse |
| ser_in | input | 1 | Received serial data |
| mask_wr | input | 1 | Write strobe for the block mask |
| mask_wdata | input | 32 | New block mask, bit i for timeslot i |
| mf_mode | input | 1 | 1 selects one sync pulse per 16-frame multiframe |
| ser_out | output | 1 | Serial data retimed by one clock |
| chan_strobe | output | 1 | High during the LSB of each timeslot |
| chan_block | output | 1 | Per-timeslot mask output |
| sync_out | output | 1 | Frame or multiframe boundary pulse |

## Verification
Two functions can fall in the same clock: a mask write and a timeslot boundary. The bench provokes this by writing the mask exactly in the clock whose bit index is 7, and again by writing it in the same clock as a mid-frame realignment pulse. In both cases the new mask must govern the very next timeslot. It must also leave the block value of the current timeslot intact for its last bit. A write made mid-timeslot is sent alongside as a contrast, and it must wait for the boundary.

// File: rtl/e1rt_pkg.sv
package e1rt_pkg;

  typedef struct packed {
    logic chan_last;    // current position is the LSB of a timeslot
    logic frame_first;  // current position is bit 0 of a frame
    logic mf_first;     // bit 0 of frame 0 of the multiframe
  } e1rt_evt_t;

  function automatic int chan_of(int pos, int bits);
    return pos / bits;
  endfunction

  function automatic int bit_of(int pos, int bits);
    return pos % bits;
  endfunction

  function automatic logic is_chan_end(int pos, int bits);
    return (pos % bits) == (bits - 1);
  endfunction

endpackage

// File: rtl/e1rt_bit_counter.sv
module e1rt_bit_counter
  import e1rt_pkg::*;
#(
  parameter int CHANS     = 32,
  parameter int BITS      = 8,
  parameter int MF_FRAMES = 16,
  parameter int CNT_W     = $clog2(CHANS * BITS),
  parameter int FR_W      = $clog2(MF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             align_in,
  output logic             aligned_o,
  output logic [CNT_W-1:0] pos_o,
  output e1rt_evt_t        evt_o
);

  localparam int LAST_POS   = CHANS * BITS - 1;
  localparam int LAST_FRAME = MF_FRAMES - 1;

  logic [FR_W-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aligned_o <= 1'b0;
      pos_o     <= '0;
      frame_q   <= '0;
    end else if (align_in) begin
      aligned_o <= 1'b1;
      pos_o     <= '0;
      frame_q   <= '0;
    end else if (aligned_o) begin
      if (int'(pos_o) == LAST_POS) begin
        pos_o   <= '0;
        frame_q <= (int'(frame_q) == LAST_FRAME) ? '0 : frame_q + 1'b1;
      end else begin
        pos_o <= pos_o + 1'b1;
      end
    end
  end

  always_comb begin
    evt_o.chan_last   = aligned_o && is_chan_end(int'(pos_o), BITS);
    evt_o.frame_first = aligned_o && (pos_o == '0);
    evt_o.mf_first    = aligned_o && (pos_o == '0) && (frame_q == '0);
  end

endmodule

// File: rtl/e1rt_mask_bank.sv
module e1rt_mask_bank #(
  parameter int CHANS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CHANS-1:0] wdata,
  input  logic             load,
  output logic [CHANS-1:0] active_o
);

  for (genvar i = 0; i < CHANS; i++) begin : g_ch
    logic shadow_q;
    logic act_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= 1'b0;
        act_q    <= 1'b0;
      end else begin
        if (wr)   shadow_q <= wdata[i];
        if (load) act_q    <= wr ? wdata[i] : shadow_q;
      end
    end

    assign active_o[i] = act_q;
  end

endmodule

// File: rtl/e1rt_out_stage.sv
module e1rt_out_stage
  import e1rt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      aligned,
  input  e1rt_evt_t evt,
  input  logic      mf_mode,
  input  logic      blk_bit,
  input  logic      ser_in,
  output logic      ser_out,
  output logic      chan_strobe,
  output logic      chan_block,
  output logic      sync_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out     <= 1'b0;
      chan_strobe <= 1'b0;
      chan_block  <= 1'b0;
      sync_out    <= 1'b0;
    end else begin
      ser_out     <= aligned && ser_in;
      chan_strobe <= evt.chan_last;
      chan_block  <= aligned && blk_bit;
      sync_out    <= mf_mode ? evt.mf_first : evt.frame_first;
    end
  end

endmodule

// File: rtl/e1_rx_chan_timing.sv
module e1_rx_chan_timing
  import e1rt_pkg::*;
#(
  parameter int CHANS     = 32,
  parameter int BITS      = 8,
  parameter int MF_FRAMES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             align_in,
  input  logic             ser_in,
  input  logic             mask_wr,
  input  logic [CHANS-1:0] mask_wdata,
  input  logic             mf_mode,
  output logic             ser_out,
  output logic             chan_strobe,
  output logic             chan_block,
  output logic             sync_out
);

  localparam int CNT_W = $clog2(CHANS * BITS);
  localparam int CH_W  = $clog2(CHANS);
  localparam int FR_W  = $clog2(MF_FRAMES);

  logic             aligned;
  logic [CNT_W-1:0] pos;
  e1rt_evt_t        evt;
  logic             mask_swap;
  logic [CHANS-1:0] active;
  logic [CH_W-1:0]  ch_idx;
  logic             blk_bit;

  e1rt_bit_counter #(
    .CHANS(CHANS), .BITS(BITS), .MF_FRAMES(MF_FRAMES),
    .CNT_W(CNT_W), .FR_W(FR_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .align_in(align_in),
    .aligned_o(aligned), .pos_o(pos), .evt_o(evt)
  );

  // the active mask may change only where a new timeslot begins next
  assign mask_swap = !aligned || align_in || evt.chan_last;

  e1rt_mask_bank #(.CHANS(CHANS)) u_mask (
    .clk(clk), .rst(rst), .wr(mask_wr), .wdata(mask_wdata),
    .load(mask_swap), .active_o(active)
  );

  assign ch_idx  = CH_W'(chan_of(int'(pos), BITS));
  assign blk_bit = active[ch_idx];

  e1rt_out_stage u_out (
    .clk(clk), .rst(rst), .aligned(aligned), .evt(evt),
    .mf_mode(mf_mode), .blk_bit(blk_bit), .ser_in(ser_in),
    .ser_out(ser_out), .chan_strobe(chan_strobe),
    .chan_block(chan_block), .sync_out(sync_out)
  );

endmodule

// File: rtl/e1rt_checker.sv
module e1rt_checker
  import e1rt_pkg::*;
#(
  parameter int CHANS = 32,
  parameter int BITS  = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             align_in,
  input logic             aligned,
  input logic [CNT_W-1:0] pos,
  input logic             mask_swap,
  input logic [CHANS-1:0] active,
  input logic             ser_out,
  input logic             chan_strobe,
  input logic             chan_block,
  input logic             sync_out
);

  // R1
  prealign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !aligned |=> (!ser_out && !chan_strobe && !chan_block && !sync_out));

  // R2
  align_load_chk: assert property (@(posedge clk) disable iff (rst)
    align_in |=> (aligned && pos == '0));

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    chan_strobe |=> !chan_strobe);

  // R5
  sync_single_chk: assert property (@(posedge clk) disable iff (rst)
    sync_out |=> !sync_out);

  // R5
  sync_pos_chk: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> $past(pos) == '0);

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_swap |=> $stable(active));

  // R7
  block_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (aligned && !align_in && bit_of(int'(pos), BITS) != 0) |=> $stable(chan_block));

endmodule

bind e1_rx_chan_timing e1rt_checker #(
  .CHANS(CHANS), .BITS(BITS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .align_in(align_in), .aligned(aligned), .pos(pos),
  .mask_swap(mask_swap), .active(active), .ser_out(ser_out),
  .chan_strobe(chan_strobe), .chan_block(chan_block), .sync_out(sync_out)
);

// File: tb/sim_e1_rx_chan_timing.sv
module sim_e1_rx_chan_timing;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        align_in = 1'b0;
  logic        ser_in = 1'b0;
  logic        mask_wr = 1'b0;
  logic [31:0] mask_wdata = '0;
  logic        mf_mode = 1'b0;
  logic        ser_out, chan_strobe, chan_block, sync_out;

  int checks = 0;
  int errors = 0;
  int printed = 0;
  int sync_seen = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference state, from the requirements
  logic        m_al = 1'b0;
  int          m_pos = 0;
  int          m_fr = 0;
  logic [31:0] m_act = '0;
  logic [31:0] m_pend = '0;

  always #(CLK_P/2) clk = ~clk;

  e1_rx_chan_timing u0 (
    .clk(clk), .rst(rst), .align_in(align_in), .ser_in(ser_in),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mf_mode(mf_mode),
    .ser_out(ser_out), .chan_strobe(chan_strobe),
    .chan_block(chan_block), .sync_out(sync_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      if (printed < 20) begin
        printed++;
        $display("FAIL %s: got %0b expected %0b (ref pos %0d)", req, act, exp, m_pos);
      end
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: drive inputs, predict, clock, compare
  task automatic cyc(input logic p, input logic w, input logic [31:0] d);
    logic e_ser, e_stb, e_blk, e_syn, swap;
    logic [31:0] np;
    lfsr       = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ser_in     = lfsr[0];
    align_in   = p;
    mask_wr    = w;
    mask_wdata = d;
    if (rst) begin
      {e_ser, e_stb, e_blk, e_syn} = '0;
      m_al = 0; m_pos = 0; m_fr = 0; m_act = '0; m_pend = '0;
    end else begin
      e_ser = m_al && ser_in;
      e_stb = m_al && (m_pos % 8 == 7);
      e_blk = m_al && m_act[m_pos / 8];
      e_syn = m_al && (m_pos == 0) && (!mf_mode || m_fr == 0);
      swap  = !m_al || p || (m_pos % 8 == 7);
      np    = w ? d : m_pend;
      if (swap) m_act = np;
      m_pend = np;
      if (p) begin
        m_al = 1; m_pos = 0; m_fr = 0;
      end else if (m_al) begin
        if (m_pos == 255) begin
          m_pos = 0; m_fr = (m_fr + 1) % 16;
        end else m_pos++;
      end
    end
    @(posedge clk);
    #(CLK_P/4);
    if (sync_out) sync_seen++;
    chk("R3 ser_out", ser_out, e_ser);
    chk("R4 chan_strobe", chan_strobe, e_stb);
    chk("R7/R8 chan_block", chan_block, e_blk);
    chk(mf_mode ? "R6 sync_out" : "R5 sync_out", sync_out, e_syn);
    align_in = 1'b0;
    mask_wr  = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0);
  endtask

  task automatic seek_bit(input int b);
    while (m_pos % 8 != b) cyc(1'b0, 1'b0, '0);
  endtask

  task automatic t_reset_idle();
    rst = 1'b1;
    cyc(1'b0, 1'b0, '0);
    cyc(1'b0, 1'b0, '0);
    rst = 1'b0;
    // R1: no alignment yet, outputs stay low even with a mask written
    cyc(1'b0, 1'b1, 32'hFFFF_FFFF);
    run(40);
    chk("R1 quiet ser_out", ser_out, 1'b0);
    chk("R1 quiet chan_block", chan_block, 1'b0);
  endtask

  task automatic t_frame_mode();
    mf_mode = 1'b0;
    cyc(1'b0, 1'b1, 32'hA5C3_0F96);
    cyc(1'b1, 1'b0, '0);               // R2 alignment
    sync_seen = 0;
    run(3 * 256);                      // R2 R3 R4 R5 R7
    chk_int("R5 syncs in 3 frames", sync_seen, 3);
  endtask

  task automatic t_mask_boundary();
    seek_bit(3);
    cyc(1'b0, 1'b1, 32'h5A5A_F00F);    // R8 mid-timeslot write
    run(20);
    seek_bit(7);
    cyc(1'b0, 1'b1, 32'h0FF0_3CC3);    // R8 write in the LSB clock
    run(40);
    seek_bit(7);
    cyc(1'b0, 1'b1, 32'hFFFF_0000);    // R8 again, different pattern
    run(300);
  endtask

  task automatic t_multiframe();
    mf_mode = 1'b1;
    cyc(1'b1, 1'b0, '0);               // R6 frame count restarts
    sync_seen = 0;
    run(17 * 256);
    chk_int("R6 syncs in 17 frames", sync_seen, 2);
    mf_mode = 1'b0;
  endtask

  task automatic t_realign();
    while (m_pos != 100) cyc(1'b0, 1'b0, '0);
    cyc(1'b1, 1'b1, 32'h8000_0001);    // R9 realign together with a write
    chk("R9 no sync on realign edge", sync_out, 1'b0);
    cyc(1'b0, 1'b0, '0);
    chk("R9 sync after realign", sync_out, 1'b1);
    chk("R9 block ts0 after realign", chan_block, 1'b1);
    run(300);
  endtask

  task automatic t_reset_mid();
    run(37);
    rst = 1'b1;
    cyc(1'b0, 1'b0, '0);
    rst = 1'b0;
    chk("R10 reset low strobe", chan_strobe, 1'b0);
    run(300);                          // R10 remains quiet without a pulse
    chk("R10 no sync without alignment", sync_out, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_idle();
    t_frame_mode();
    t_mask_boundary();
    t_multiframe();
    t_realign();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule